// File: doc/BRIEF.md
# Staged Memory Fill Engine

This engine performs a single stage of a byte fill that software splits into three consecutive steps: an opening step, a bulk step and a closing step. For each stage it receives a destination-address register, a byte-count register, a data register whose lowest byte is the fill value, the current condition flags and a 2-bit stage code. It then stores the fill byte over its share of the region through a write port that carries byte strobes and accepts one block per acknowledgement. When the stage ends it returns the updated address and count registers, the flags and a status.

Two register conventions exist, and a static parameter selects one of them. In the negative-count convention the address register holds the end of the region and the count register holds minus the bytes still to fill. In the positive-count convention the address register holds the first unfilled byte and the count register holds the bytes still to fill. The opening step records the convention in the carry flag. The later steps check that flag against the configured convention.

Top module: `mfill_stage_engine`

## Requirements
- R1: Stage code 00 is the opening step, 01 the bulk step and 10 the closing step. Code 11 raises `err_undef`, issues no write, and returns the address, count and flags inputs unchanged.
- R2: In the opening step the count is unsigned. A count with bit 63 set is replaced by 0x7FFF_FFFF_FFFF_FFFF before any other use.
- R3: Negative-count opening step: `res_addr` is the input address plus the clamped size, `res_count` is minus the bytes still unfilled, and `res_flags` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) is 0000.
- R4: Positive-count opening step: `res_addr` is the first unfilled address, `res_count` is the positive number of bytes still unfilled, and `res_flags` is 0010.
- R5: In the bulk and closing steps the count is signed. Carry clear means negative-count and carry set means positive-count. A carry that differs from the configured convention raises `err_conv`, issues no write, and returns the inputs unchanged.
- R6: Negative-count bulk and closing steps write starting at address plus count. `res_addr` equals the input address, and `res_count` rises toward zero by the bytes written.
- R7: Positive-count bulk and closing steps write starting at the address register. `res_addr` rises and `res_count` falls by the bytes written.
- R8: Every strobed lane of `wr_data` carries the lowest byte of `data_in`. The strobes are contiguous, start at lane `wr_addr[2:0]` and never cross an 8-byte line.
- R9: The opening step writes only up to the next 8-byte-aligned address. The bulk step writes only whole aligned 8-byte blocks, and writes nothing if its start is unaligned. The closing step writes all remaining bytes and leaves `res_count` at 0.
- R10: If `wr_count` differs from the strobed byte count of the acknowledged block, the stage stops, `fault` is set, and the result registers reflect only the fully completed blocks. A later fault-free stage clears `fault`.
- R11: `res_flags` changes only in the opening step. The bulk and closing steps return `flags_in` as given.
- R12: `start` is taken only while idle. `busy` is high while blocks are being issued. `done` is a single-cycle pulse. `wr_req` holds its address and strobes until it is acknowledged. `wr_nt` mirrors `non_temporal` for the whole stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one stage (taken when idle) |
| stage_code | input | 2 | 00 opening, 01 bulk, 10 closing, 11 undefined |
| non_temporal | input | 1 | Marks the stage's writes as streaming |
| addr_in | input | 64 | Address register value |
| count_in | input | 64 | Count register value |
| data_in | input | 64 | Data register; low byte is the fill value |
| flags_in | input | 4 | Incoming N,Z,C,V (bits 3..0) |
| busy | output | 1 | Stage issuing blocks |
| done | output | 1 | One-cycle end-of-stage pulse |
| fault | output | 1 | Stage stopped on a short write |
| err_undef | output | 1 | Stage code 11 was given |
| err_conv | output | 1 | Carry disagrees with the configured convention |
| res_addr | output | 64 | Updated address register |
| res_count | output | 64 | Updated count register |
| res_flags | output | 4 | Updated N,Z,C,V |
| wr_req | output | 1 | Block write request |
| wr_addr | output | 64 | Byte address of the first strobed lane |
| wr_data | output | 64 | Replicated fill byte |
| wr_strb | output | 8 | Byte lane strobes |
| wr_nt | output | 1 | Streaming hint for the write |
| wr_ack | input | 1 | Write acknowledgement |
| wr_count | input | 4 | Bytes actually completed by the acknowledged write |

## Verification
Two events can fall in the same clock edge: the acknowledgement that would complete a stage's last block, and the detection of a short write that ends the stage with a fault. The bench provokes this by returning a short byte count on the only block of a closing step, and also on a middle block of a bulk step. It judges the result by `fault` being set, by the count register keeping the value it had before the failed block, and by no further request being issued. A fault-free stage that follows must clear the flag.

// File: rtl/mfill_pkg.sv
package mfill_pkg;

  localparam int unsigned REG_W  = 64;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLAG_C = 1;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [1:0] {
    STG_OPEN  = 2'b00,
    STG_BULK  = 2'b01,
    STG_CLOSE = 2'b10,
    STG_BAD   = 2'b11
  } stage_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_RUN  = 2'd1,
    FSM_FIN  = 2'd2
  } fsm_e;

  // Work plan for one stage, in convention-free form.
  typedef struct packed {
    word_t pos;    // first byte still to fill
    word_t rem;    // bytes still to fill in the whole region
    word_t quota;  // bytes this stage will fill
    logic  undef;
    logic  conv;
  } plan_t;

  function automatic word_t clamp_size(word_t c);
    return c[REG_W-1] ? {1'b0, {(REG_W-1){1'b1}}} : c;
  endfunction

  function automatic word_t umin(word_t a, word_t b);
    return (a < b) ? a : b;
  endfunction

  // Bytes from p up to the next line boundary (0 when already aligned).
  function automatic word_t gap_to_line(word_t p, word_t mask);
    return (word_t'(0) - p) & mask;
  endfunction

  function automatic word_t neg_remaining(word_t c);
    return c[REG_W-1] ? (word_t'(0) - c) : '0;
  endfunction

  function automatic word_t pos_remaining(word_t c);
    return c[REG_W-1] ? '0 : c;
  endfunction

  function automatic word_t out_count(logic neg, word_t rem);
    return neg ? (word_t'(0) - rem) : rem;
  endfunction

  function automatic word_t out_addr(logic neg, word_t p, word_t rem);
    return neg ? (p + rem) : p;
  endfunction

  function automatic logic [FLAG_W-1:0] open_flags(logic neg);
    return neg ? 4'b0000 : 4'b0010;
  endfunction

endpackage

// File: rtl/mfill_plan.sv
module mfill_plan
  import mfill_pkg::*;
#(
  parameter bit          NEG_COUNT = 1'b1,
  parameter int unsigned BLK_BYTES = 8
) (
  input  logic [1:0] stage_code,
  input  word_t      addr_in,
  input  word_t      count_in,
  input  logic       carry_in,
  output plan_t      plan
);

  localparam word_t LINE_MASK = word_t'(BLK_BYTES - 1);

  word_t size_w;
  word_t pos_w;
  word_t rem_w;
  logic  aligned_w;

  assign size_w    = clamp_size(count_in);
  assign pos_w     = NEG_COUNT ? (addr_in + count_in) : addr_in;
  assign rem_w     = NEG_COUNT ? neg_remaining(count_in) : pos_remaining(count_in);
  assign aligned_w = ((pos_w & LINE_MASK) == '0);

  always_comb begin
    plan = '0;
    case (stage_e'(stage_code))
      STG_OPEN: begin
        plan.pos   = addr_in;
        plan.rem   = size_w;
        plan.quota = umin(size_w, gap_to_line(addr_in, LINE_MASK));
      end
      STG_BULK: begin
        plan.conv  = (carry_in == NEG_COUNT);
        plan.pos   = pos_w;
        plan.rem   = rem_w;
        plan.quota = aligned_w ? (rem_w & ~LINE_MASK) : '0;
      end
      STG_CLOSE: begin
        plan.conv  = (carry_in == NEG_COUNT);
        plan.pos   = pos_w;
        plan.rem   = rem_w;
        plan.quota = rem_w;
      end
      default: plan.undef = 1'b1;
    endcase
  end

endmodule

// File: rtl/mfill_blockgen.sv
module mfill_blockgen
  import mfill_pkg::*;
#(
  parameter  int unsigned BLK_BYTES = 8,
  localparam int unsigned LANE_W    = $clog2(BLK_BYTES)
) (
  input  word_t                  pos,
  input  word_t                  left,
  input  logic [7:0]             fill,
  output logic [LANE_W:0]        blen,
  output logic [BLK_BYTES-1:0]   strb,
  output logic [8*BLK_BYTES-1:0] wdata
);

  localparam word_t LINE_MASK = word_t'(BLK_BYTES - 1);

  word_t            gap_w;
  word_t            room_w;
  word_t            take_w;
  logic [LANE_W:0]  off_w;

  assign gap_w  = gap_to_line(pos, LINE_MASK);
  assign room_w = (gap_w == '0) ? word_t'(BLK_BYTES) : gap_w;
  assign take_w = umin(left, room_w);
  assign blen   = take_w[LANE_W:0];
  assign off_w  = {1'b0, pos[LANE_W-1:0]};

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    localparam logic [LANE_W:0] IDX = (LANE_W+1)'(g);
    assign strb[g]          = (IDX >= off_w) && (IDX < (off_w + blen));
    assign wdata[8*g +: 8]  = fill;
  end

endmodule

// File: rtl/mfill_ctrl.sv
module mfill_ctrl
  import mfill_pkg::*;
#(
  parameter  int unsigned BLK_BYTES = 8,
  localparam int unsigned LANE_W    = $clog2(BLK_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  plan_t           plan,
  input  logic            wr_ack,
  input  logic [LANE_W:0] wr_count,
  input  logic [LANE_W:0] blen,
  output word_t           pos_q,
  output word_t           rem_q,
  output word_t           left_q,
  output logic            fault_q,
  output logic            undef_q,
  output logic            conv_q,
  output logic            idle,
  output logic            busy,
  output logic            done,
  output logic            wr_req,
  output logic            blk_full,
  output logic            blk_short
);

  fsm_e  st_q;
  word_t blen_w;

  assign idle      = (st_q == FSM_IDLE);
  assign busy      = (st_q == FSM_RUN);
  assign done      = (st_q == FSM_FIN);
  assign wr_req    = busy && (left_q != '0);
  assign blk_full  = wr_req && wr_ack && (wr_count == blen);
  assign blk_short = wr_req && wr_ack && (wr_count != blen);
  assign blen_w    = word_t'(blen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FSM_IDLE;
      pos_q   <= '0;
      rem_q   <= '0;
      left_q  <= '0;
      fault_q <= 1'b0;
      undef_q <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      case (st_q)
        FSM_IDLE: begin
          if (launch) begin
            pos_q   <= plan.pos;
            rem_q   <= plan.rem;
            left_q  <= plan.quota;
            fault_q <= 1'b0;
            undef_q <= plan.undef;
            conv_q  <= plan.conv;
            st_q    <= (plan.undef || plan.conv) ? FSM_FIN : FSM_RUN;
          end
        end
        FSM_RUN: begin
          if (left_q == '0) begin
            st_q <= FSM_FIN;
          end else if (blk_full) begin
            pos_q  <= pos_q + blen_w;
            rem_q  <= rem_q - blen_w;
            left_q <= left_q - blen_w;
          end else if (blk_short) begin
            fault_q <= 1'b1;
            st_q    <= FSM_FIN;
          end
        end
        FSM_FIN: st_q <= FSM_IDLE;
        default: st_q <= FSM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mfill_stage_engine.sv
module mfill_stage_engine
  import mfill_pkg::*;
#(
  parameter  bit          NEG_COUNT = 1'b1,
  parameter  int unsigned BLK_BYTES = 8,
  localparam int unsigned LANE_W    = $clog2(BLK_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             stage_code,
  input  logic                   non_temporal,
  input  logic [REG_W-1:0]       addr_in,
  input  logic [REG_W-1:0]       count_in,
  input  logic [REG_W-1:0]       data_in,
  input  logic [FLAG_W-1:0]      flags_in,
  output logic                   busy,
  output logic                   done,
  output logic                   fault,
  output logic                   err_undef,
  output logic                   err_conv,
  output logic [REG_W-1:0]       res_addr,
  output logic [REG_W-1:0]       res_count,
  output logic [FLAG_W-1:0]      res_flags,
  output logic                   wr_req,
  output logic [REG_W-1:0]       wr_addr,
  output logic [8*BLK_BYTES-1:0] wr_data,
  output logic [BLK_BYTES-1:0]   wr_strb,
  output logic                   wr_nt,
  input  logic                   wr_ack,
  input  logic [LANE_W:0]        wr_count
);

  plan_t              plan_w;
  logic               idle_w;
  logic               launch_w;
  logic               blk_full;
  logic               blk_short;
  logic               undef_q;
  logic               conv_q;
  logic               fault_q;
  logic               err_any;
  word_t              pos_q;
  word_t              rem_q;
  word_t              left_q;
  logic [LANE_W:0]    blen_w;

  logic [1:0]         stage_q;
  word_t              addr_q;
  word_t              cnt_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [7:0]         fill_q;
  logic               nt_q;

  assign launch_w = start && idle_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
      fill_q  <= '0;
      nt_q    <= 1'b0;
    end else if (launch_w) begin
      stage_q <= stage_code;
      addr_q  <= addr_in;
      cnt_q   <= count_in;
      flags_q <= flags_in;
      fill_q  <= data_in[7:0];
      nt_q    <= non_temporal;
    end
  end

  mfill_plan #(
    .NEG_COUNT (NEG_COUNT),
    .BLK_BYTES (BLK_BYTES)
  ) u_plan (
    .stage_code (stage_code),
    .addr_in    (addr_in),
    .count_in   (count_in),
    .carry_in   (flags_in[FLAG_C]),
    .plan       (plan_w)
  );

  mfill_ctrl #(
    .BLK_BYTES (BLK_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_w),
    .plan      (plan_w),
    .wr_ack    (wr_ack),
    .wr_count  (wr_count),
    .blen      (blen_w),
    .pos_q     (pos_q),
    .rem_q     (rem_q),
    .left_q    (left_q),
    .fault_q   (fault_q),
    .undef_q   (undef_q),
    .conv_q    (conv_q),
    .idle      (idle_w),
    .busy      (busy),
    .done      (done),
    .wr_req    (wr_req),
    .blk_full  (blk_full),
    .blk_short (blk_short)
  );

  mfill_blockgen #(
    .BLK_BYTES (BLK_BYTES)
  ) u_blk (
    .pos   (pos_q),
    .left  (left_q),
    .fill  (fill_q),
    .blen  (blen_w),
    .strb  (wr_strb),
    .wdata (wr_data)
  );

  assign err_any   = undef_q || conv_q;
  assign wr_addr   = pos_q;
  assign wr_nt     = nt_q;
  assign fault     = fault_q;
  assign err_undef = undef_q;
  assign err_conv  = conv_q;
  assign res_addr  = err_any ? addr_q : out_addr(NEG_COUNT, pos_q, rem_q);
  assign res_count = err_any ? cnt_q  : out_count(NEG_COUNT, rem_q);
  assign res_flags = (!err_any && (stage_e'(stage_q) == STG_OPEN)) ?
                     open_flags(NEG_COUNT) : flags_q;

endmodule

// File: rtl/mfill_stage_engine_chk.sv
module mfill_stage_engine_chk #(
  parameter  int unsigned BLK_BYTES = 8,
  localparam int unsigned LANE_W    = $clog2(BLK_BYTES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   fault,
  input logic                   err_undef,
  input logic                   err_conv,
  input logic                   wr_req,
  input logic                   wr_ack,
  input logic [63:0]            wr_addr,
  input logic [8*BLK_BYTES-1:0] wr_data,
  input logic [BLK_BYTES-1:0]   wr_strb,
  input logic                   blk_short
);

  // R12: end-of-stage pulse lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: requests only while the stage is running
  a_r12_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);

  // R12: an unacknowledged request keeps its address and strobes
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_strb)));

  // R8: every lane carries the same fill byte
  a_r8_fill_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_data == {BLK_BYTES{wr_data[7:0]}}));

  // R8: strobes begin at the address lane
  a_r8_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_strb[wr_addr[LANE_W-1:0]]);

  // R9: a block never crosses a line
  a_r9_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ((int'(wr_addr[LANE_W-1:0]) + $countones(wr_strb)) <= int'(BLK_BYTES)));

  // R10: a short write ends the stage with the fault flag
  a_r10_short_stops: assert property (@(posedge clk) disable iff (!rst_n)
    blk_short |=> (done && fault));

  // R1 / R5: a rejected stage never runs
  a_r1_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_undef || err_conv) |-> !busy);

endmodule

bind mfill_stage_engine mfill_stage_engine_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .err_undef (err_undef),
  .err_conv  (err_conv),
  .wr_req    (wr_req),
  .wr_ack    (wr_ack),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_strb   (wr_strb),
  .blk_short (blk_short)
);

// File: tb/mfill_stage_engine_tb.sv
module mfill_stage_engine_tb;

  localparam int BLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  stage_code = '0;
  logic        nt = 1'b0;
  logic [63:0] addr_in = '0, count_in = '0, data_in = '0;
  logic [3:0]  flags_in = '0;

  logic        start_v [2] = '{1'b0, 1'b0};
  logic        busy_v [2], done_v [2], fault_v [2], eu_v [2], ec_v [2];
  logic [63:0] ra_v [2], rc_v [2];
  logic [3:0]  rf_v [2];
  logic        req_v [2], ntv_v [2];
  logic [63:0] wa_v [2], wd_v [2];
  logic [7:0]  strb_v [2];
  logic        ack_v [2] = '{1'b0, 1'b0};
  logic [3:0]  wc_v [2] = '{4'd0, 4'd0};

  mfill_stage_engine #(.NEG_COUNT(1'b1), .BLK_BYTES(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_v[0]), .stage_code(stage_code),
    .non_temporal(nt), .addr_in(addr_in), .count_in(count_in), .data_in(data_in),
    .flags_in(flags_in), .busy(busy_v[0]), .done(done_v[0]), .fault(fault_v[0]),
    .err_undef(eu_v[0]), .err_conv(ec_v[0]), .res_addr(ra_v[0]), .res_count(rc_v[0]),
    .res_flags(rf_v[0]), .wr_req(req_v[0]), .wr_addr(wa_v[0]), .wr_data(wd_v[0]),
    .wr_strb(strb_v[0]), .wr_nt(ntv_v[0]), .wr_ack(ack_v[0]), .wr_count(wc_v[0]));

  mfill_stage_engine #(.NEG_COUNT(1'b0), .BLK_BYTES(BLK)) u_dut_pos (
    .clk(clk), .rst_n(rst_n), .start(start_v[1]), .stage_code(stage_code),
    .non_temporal(nt), .addr_in(addr_in), .count_in(count_in), .data_in(data_in),
    .flags_in(flags_in), .busy(busy_v[1]), .done(done_v[1]), .fault(fault_v[1]),
    .err_undef(eu_v[1]), .err_conv(ec_v[1]), .res_addr(ra_v[1]), .res_count(rc_v[1]),
    .res_flags(rf_v[1]), .wr_req(req_v[1]), .wr_addr(wa_v[1]), .wr_data(wd_v[1]),
    .wr_strb(strb_v[1]), .wr_nt(ntv_v[1]), .wr_ack(ack_v[1]), .wr_count(wc_v[1]));

  int n_chk = 0, n_err = 0;
  int nwr [2], nbytes [2], fill_err [2], nt_err [2], fault_blk [2], short_n [2];
  logic [63:0] first_wa [2];

  initial begin
    for (int i = 0; i < 2; i++) begin
      nwr[i] = 0; nbytes[i] = 0; fill_err[i] = 0; nt_err[i] = 0;
      fault_blk[i] = -1; short_n[i] = 0; first_wa[i] = '0;
    end
  end

  // Write-port model: answers each request at the falling edge.
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst_n && req_v[i]) begin
        if (nwr[i] == 0) first_wa[i] = wa_v[i];
        for (int b = 0; b < BLK; b++)
          if (strb_v[i][b] && (wd_v[i][8*b +: 8] !== data_in[7:0])) fill_err[i]++;
        if (ntv_v[i] !== nt) nt_err[i]++;
        wc_v[i]  = (nwr[i] == fault_blk[i]) ? 4'(short_n[i]) : 4'($countones(strb_v[i]));
        ack_v[i] = 1'b1;
        nbytes[i] += $countones(strb_v[i]);
        nwr[i]++;
      end else begin
        ack_v[i] = 1'b0;
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic run_op(int k, logic [1:0] sc, logic [63:0] a, logic [63:0] c,
                        logic [3:0] f, logic [7:0] d, logic ntv);
    int guard;
    @(negedge clk);
    stage_code = sc; addr_in = a; count_in = c; flags_in = f;
    data_in = {56'hA5_96_C3_0F_E1_78_B4, d}; nt = ntv;
    nwr[k] = 0; nbytes[k] = 0; fill_err[k] = 0; nt_err[k] = 0; first_wa[k] = '0;
    start_v[k] = 1'b1;
    @(negedge clk);
    start_v[k] = 1'b0;
    guard = 0;
    while (!done_v[k] && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check("R12 stage reaches done", 64'(done_v[k]), 64'd1);
  endtask

  typedef struct packed {
    logic [1:0]  sc;
    logic [63:0] a;
    logic [63:0] c;
    logic [3:0]  f;
    logic [7:0]  d;
    logic [63:0] ea;
    logic [63:0] ec;
    logic [3:0]  ef;
    logic [1:0]  ee;   // {undef, conv}
    logic [7:0]  en;   // block writes
    logic [15:0] eb;   // bytes strobed
    logic [63:0] ew;   // first write address
  } vec_t;

  // Negative-count instance vectors.
  localparam vec_t VEC [12] = '{
    '{2'b00, 64'h1003, 64'd20, 4'hF, 8'h5A, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF1, 4'h0, 2'b00, 8'd1, 16'd5, 64'h1003},
    '{2'b01, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF1, 4'h0, 8'h3C, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF9, 4'h0, 2'b00, 8'd1, 16'd8, 64'h1008},
    '{2'b10, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF9, 4'h0, 8'hC3, 64'h1017, 64'h0, 4'h0, 2'b00, 8'd1, 16'd7, 64'h1010},
    '{2'b00, 64'h1040, 64'd24, 4'h4, 8'h11, 64'h1058, 64'hFFFF_FFFF_FFFF_FFE8, 4'h0, 2'b00, 8'd0, 16'd0, 64'h0},
    '{2'b01, 64'h1058, 64'hFFFF_FFFF_FFFF_FFE8, 4'h8, 8'h22, 64'h1058, 64'h0, 4'h8, 2'b00, 8'd3, 16'd24, 64'h1040},
    // R2: count with top bit set is clamped before use
    '{2'b00, 64'h1001, 64'h8000_0000_0000_0005, 4'h0, 8'h33, 64'h8000_0000_0000_1000, 64'h8000_0000_0000_0008, 4'h0, 2'b00, 8'd1, 16'd7, 64'h1001},
    '{2'b11, 64'h1000, 64'd5, 4'h5, 8'h44, 64'h1000, 64'd5, 4'h5, 2'b10, 8'd0, 16'd0, 64'h0},
    '{2'b01, 64'h1058, 64'hFFFF_FFFF_FFFF_FFF8, 4'h2, 8'h55, 64'h1058, 64'hFFFF_FFFF_FFFF_FFF8, 4'h2, 2'b01, 8'd0, 16'd0, 64'h0},
    '{2'b10, 64'h1090, 64'hFFFF_FFFF_FFFF_FFF3, 4'h1, 8'h66, 64'h1090, 64'h0, 4'h1, 2'b00, 8'd2, 16'd13, 64'h1083},
    '{2'b01, 64'h10A0, 64'hFFFF_FFFF_FFFF_FFF6, 4'h0, 8'h77, 64'h10A0, 64'hFFFF_FFFF_FFFF_FFF6, 4'h0, 2'b00, 8'd0, 16'd0, 64'h0},
    '{2'b00, 64'h10B5, 64'h0, 4'h2, 8'h88, 64'h10B5, 64'h0, 4'h0, 2'b00, 8'd0, 16'd0, 64'h0},
    '{2'b01, 64'h10C0, 64'h0, 4'h0, 8'h99, 64'h10C0, 64'h0, 4'h0, 2'b00, 8'd0, 16'd0, 64'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset busy", 64'(busy_v[0]), 64'd0);
    check("R12 reset done", 64'(done_v[0]), 64'd0);
    check("R12 reset wr_req", 64'(req_v[0]), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      run_op(0, VEC[v].sc, VEC[v].a, VEC[v].c, VEC[v].f, VEC[v].d, v[0]);
      check((VEC[v].sc == 2'b00) ? "R3 res_addr" : "R6 res_addr", ra_v[0], VEC[v].ea);
      check((VEC[v].sc == 2'b00) ? "R3 res_count" : "R9 res_count", rc_v[0], VEC[v].ec);
      check("R11 res_flags", 64'(rf_v[0]), 64'(VEC[v].ef));
      check("R1 R5 error bits", 64'({eu_v[0], ec_v[0]}), 64'(VEC[v].ee));
      check("R9 block writes", 64'(nwr[0]), 64'(VEC[v].en));
      check("R9 bytes strobed", 64'(nbytes[0]), 64'(VEC[v].eb));
      check("R6 first write address", first_wa[0], VEC[v].ew);
      check("R8 fill lanes", 64'(fill_err[0]), 64'd0);
      check("R12 non-temporal hint", 64'(nt_err[0]), 64'd0);
      check("R10 no fault", 64'(fault_v[0]), 64'd0);
    end

    // R12: done lasts one cycle
    @(negedge clk);
    check("R12 done pulse", 64'(done_v[0]), 64'd0);

    // Positive-count instance: R4 opening, R7 bulk, R9 closing
    run_op(1, 2'b00, 64'h1003, 64'd20, 4'h0, 8'hE7, 1'b1);
    check("R4 res_addr", ra_v[1], 64'h1008);
    check("R4 res_count", rc_v[1], 64'd15);
    check("R4 res_flags", 64'(rf_v[1]), 64'h2);
    check("R8 fill lanes pos", 64'(fill_err[1]), 64'd0);
    run_op(1, 2'b01, 64'h1008, 64'd15, 4'h2, 8'h18, 1'b0);
    check("R7 res_addr", ra_v[1], 64'h1010);
    check("R7 res_count", rc_v[1], 64'd7);
    check("R7 first write address", first_wa[1], 64'h1008);
    check("R11 flags pass", 64'(rf_v[1]), 64'h2);
    run_op(1, 2'b10, 64'h1010, 64'd7, 4'h2, 8'h18, 1'b0);
    check("R9 closing res_addr", ra_v[1], 64'h1017);
    check("R9 closing res_count", rc_v[1], 64'd0);
    check("R9 closing bytes", 64'(nbytes[1]), 64'd7);
    run_op(1, 2'b01, 64'h1008, 64'd15, 4'h0, 8'h18, 1'b0);
    check("R5 convention error", 64'(ec_v[1]), 64'd1);
    check("R5 no writes", 64'(nwr[1]), 64'd0);
    check("R5 address unchanged", ra_v[1], 64'h1008);
    run_op(1, 2'b00, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, 8'h01, 1'b0);
    check("R2 clamped count", rc_v[1], 64'h7FFF_FFFF_FFFF_FFFF);
    check("R2 address", ra_v[1], 64'h2000);

    // R10: short write on a middle block of a bulk step
    fault_blk[0] = 1; short_n[0] = 3;
    run_op(0, 2'b01, 64'h1058, 64'hFFFF_FFFF_FFFF_FFE8, 4'h0, 8'h42, 1'b0);
    check("R10 fault raised", 64'(fault_v[0]), 64'd1);
    check("R10 count after last full block", rc_v[0], 64'hFFFF_FFFF_FFFF_FFF0);
    check("R10 address", ra_v[0], 64'h1058);
    check("R10 writes stop", 64'(nwr[0]), 64'd2);

    // R10: short write on the only block of a closing step
    fault_blk[0] = 0; short_n[0] = 2;
    run_op(0, 2'b10, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF9, 4'h0, 8'h42, 1'b0);
    check("R10 final-block fault", 64'(fault_v[0]), 64'd1);
    check("R10 final-block count kept", rc_v[0], 64'hFFFF_FFFF_FFFF_FFF9);
    check("R10 single request", 64'(nwr[0]), 64'd1);

    fault_blk[0] = -1;
    run_op(0, 2'b10, 64'h1017, 64'hFFFF_FFFF_FFFF_FFF9, 4'h0, 8'h42, 1'b1);
    check("R10 fault cleared", 64'(fault_v[0]), 64'd0);
    check("R9 count zero", rc_v[0], 64'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule